// File: doc/BRIEF.md
# Sleep Mode Clock-Gating Controller

This block stands between a small processor core and its clock tree. While the core runs, every clock enable and the oscillator enable are high. When the core issues a sleep strobe and sleep is permitted, the controller latches a 3-bit mode code. It then drops the clock enables that the chosen mode switches off: core, program memory, peripheral I/O, converter and asynchronous timer. In the deeper modes it also switches the oscillator off.

While asleep, the controller watches eight wake request lines and masks them with the set of sources that the current mode allows. Any reset source ends sleep at once and raises a reset request. In the light modes, an accepted wake request restores all clocks on the next edge. In the deep modes it first turns the oscillator back on and waits a start-up delay chosen by a configuration field. It then restores the clocks and pulses `wake`. A level-type external request in a deep mode is accepted only after it has stayed high for a minimum number of cycles.

Top module: `slp_clkgate_ctrl`

## Requirements
- R1: After reset all six enables (`clk_en_cpu`, `clk_en_flash`, `clk_en_io`, `clk_en_adc`, `clk_en_atmr`, `osc_en`) are 1, and `wake`, `rst_req` and `adc_start` are 0.
- R2: A `sleep_cmd` strobe is ignored when `sleep_en` is 0 or when the block is not awake.
- R3: One edge after an accepted strobe, the enables {osc,atmr,adc,io,flash,cpu} are set by `mode_sel`. Code 000 (light idle) gives 111100. Code 001 (converter quiet) gives 111000. Code 010 (deep stop) gives 000000. Codes 100 to 111 behave exactly as 000.
- R4: Code 011 (deep save) gives 000000, except that `clk_en_atmr` equals `async_sel`.
- R5: On entering code 000, code 001 or a code from 100 to 111 while `adc_en` is 1, `adc_start` pulses for exactly one cycle. It never pulses for codes 010 and 011.
- R6: The `wake_req` bits are: 0 converter done, 1 two-wire address match, 2 timer2 interrupt, 3 memory ready, 4 external level request, 5 external edge request, 6 serial interrupt, 7 other interrupt. Light idle accepts all eight bits. Converter quiet accepts bits 0 to 5. Deep stop and deep save accept bits 1, 4 and 5.
- R7: In deep save, bit 2 is also accepted when `async_sel`, `tmr_ie` and `gie` are all 1, and only then.
- R8: In deep stop and deep save, bit 4 is accepted only on the LVL_HOLD-th consecutive edge at which it is high. In the light modes it is accepted at once.
- R9: In a light mode, an accepted request at an edge makes all enables 1 and `wake` 1 after that same edge.
- R10: In a deep mode, an accepted request turns `osc_en` on while the other clocks stay gated. `wake` and all enables follow DLY_BASE·4^`startup_sel` edges later.
- R11: Any bit of `rst_src` seen while asleep or starting up ends sleep on the next edge. That edge sets all enables to 1 and pulses `rst_req` for one cycle, without any `wake` pulse.
- R12: `wake` lasts one cycle, after which the block is awake and accepts a new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_cmd | input | 1 | One-cycle sleep strobe from the core |
| sleep_en | input | 1 | Permits the strobe to take effect |
| mode_sel | input | 3 | Sleep mode code |
| adc_en | input | 1 | Converter is enabled |
| async_sel | input | 1 | Asynchronous timer runs from its own clock |
| tmr_ie | input | 1 | Timer overflow/compare interrupt enabled |
| gie | input | 1 | Global interrupt enable |
| startup_sel | input | 2 | Oscillator start-up delay selection |
| wake_req | input | 8 | Wake request lines, bit meanings in R6 |
| rst_src | input | 3 | External, watchdog and brown-out reset sources |
| clk_en_cpu | output | 1 | Core clock enable |
| clk_en_flash | output | 1 | Program memory clock enable |
| clk_en_io | output | 1 | Peripheral I/O clock enable |
| clk_en_adc | output | 1 | Converter clock enable |
| clk_en_atmr | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Oscillator enable |
| adc_start | output | 1 | One-cycle conversion start pulse |
| wake | output | 1 | One-cycle pulse when clocks are restored |
| rst_req | output | 1 | One-cycle reset request on reset-source exit |

## Verification
The main function is driven through every mode code, with the converter enable and async select set both ways. This separates the four gating patterns, the reserved codes folding onto idle, and the single timer-clock exception. Each mode is then woken by sources inside and outside its mask. Converter-done against deep stop, other-interrupt against converter quiet, and the timer bit with `gie` on and off distinguish the per-mode masks. Level requests held too briefly and held long enough, and two start-up selections, separate the hold filter and the delay counter from the immediate light-mode wake path.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int NWK = 8;

    localparam int WK_ADC    = 0;
    localparam int WK_TWI    = 1;
    localparam int WK_TMR2   = 2;
    localparam int WK_NVM    = 3;
    localparam int WK_EXTLVL = 4;
    localparam int WK_EXT2   = 5;

    localparam logic [NWK-1:0] MASK_ALL   = '1;
    localparam logic [NWK-1:0] MASK_DEEP  = (NWK'(1) << WK_TWI) | (NWK'(1) << WK_EXTLVL)
                                          | (NWK'(1) << WK_EXT2);
    localparam logic [NWK-1:0] MASK_QUIET = MASK_DEEP | (NWK'(1) << WK_ADC)
                                          | (NWK'(1) << WK_TMR2) | (NWK'(1) << WK_NVM);
    localparam logic [NWK-1:0] MASK_TMR2  = NWK'(1) << WK_TMR2;

    typedef enum logic [1:0] {
        MD_IDLE  = 2'b00,
        MD_QUIET = 2'b01,
        MD_STOP  = 2'b10,
        MD_SAVE  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_AWAKE,
        ST_SLEEPING,
        ST_OSC_STARTUP,
        ST_RESUME
    } state_e;

    typedef struct packed {
        logic osc;
        logic atmr;
        logic adc;
        logic io;
        logic flash;
        logic cpu;
    } gate_t;

    typedef struct packed {
        state_e state;
        mode_e  mode;
        gate_t  gate;
        logic   wake;
        logic   rst_req;
        logic   adc_start;
    } ctl_t;

endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
    import slp_pkg::*;
(
    input  logic [2:0]     mode_raw_i,
    input  logic           async_i,
    input  logic           tmr_ie_i,
    input  logic           gie_i,
    output mode_e          mode_o,
    output gate_t          gate_o,
    output logic [NWK-1:0] mask_o,
    output logic           deep_o,
    output logic           adc_trig_o
);

    always_comb begin
        mode_o     = mode_raw_i[2] ? MD_IDLE : mode_e'(mode_raw_i[1:0]);
        gate_o     = '1;
        mask_o     = '0;
        deep_o     = 1'b0;
        adc_trig_o = 1'b0;
        unique case (mode_o)
            MD_IDLE: begin
                gate_o.cpu   = 1'b0;
                gate_o.flash = 1'b0;
                mask_o       = MASK_ALL;
                adc_trig_o   = 1'b1;
            end
            MD_QUIET: begin
                gate_o.cpu   = 1'b0;
                gate_o.flash = 1'b0;
                gate_o.io    = 1'b0;
                mask_o       = MASK_QUIET;
                adc_trig_o   = 1'b1;
            end
            MD_STOP: begin
                gate_o = '0;
                mask_o = MASK_DEEP;
                deep_o = 1'b1;
            end
            MD_SAVE: begin
                gate_o      = '0;
                gate_o.atmr = async_i;
                mask_o      = MASK_DEEP
                            | ((async_i && tmr_ie_i && gie_i) ? MASK_TMR2 : '0);
                deep_o      = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/slp_lvl_filter.sv
module slp_lvl_filter #(
    parameter int LVL_HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic lvl_i,
    output logic ok_o
);

    localparam int HW = $clog2(LVL_HOLD + 1);
    localparam logic [HW-1:0] TOP = HW'(LVL_HOLD - 1);

    logic [HW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i || !lvl_i)  cnt_d = '0;
        else if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
        else                   cnt_d = cnt_q;
        ok_o = lvl_i && (cnt_q == TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (LVL_HOLD > 1) begin : g_hold_chk
            // R8: acceptance needs the level to have been high on the prior edge too
            assert_lvl_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ok_o |-> $past(lvl_i));
        end
    endgenerate

endmodule

// File: rtl/slp_dly_timer.sv
module slp_dly_timer #(
    parameter int DLY_BASE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] sel_i,
    output logic       done_o
);

    localparam int MAXD = DLY_BASE * 64;
    localparam int CW   = $clog2(MAXD + 1);

    logic [CW-1:0] dly;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        dly    = CW'(DLY_BASE) << {sel_i, 1'b0};
        done_o = run_i && (cnt_q == dly - 1'b1);
        if (!run_i || done_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10: the start-up count never passes the selected delay
    assert_dly_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < dly));

endmodule

// File: rtl/slp_clkgate_ctrl.sv
module slp_clkgate_ctrl
    import slp_pkg::*;
#(
    parameter int DLY_BASE = 4,
    parameter int LVL_HOLD = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sleep_cmd,
    input  logic           sleep_en,
    input  logic [2:0]     mode_sel,
    input  logic           adc_en,
    input  logic           async_sel,
    input  logic           tmr_ie,
    input  logic           gie,
    input  logic [1:0]     startup_sel,
    input  logic [NWK-1:0] wake_req,
    input  logic [2:0]     rst_src,
    output logic           clk_en_cpu,
    output logic           clk_en_flash,
    output logic           clk_en_io,
    output logic           clk_en_adc,
    output logic           clk_en_atmr,
    output logic           osc_en,
    output logic           adc_start,
    output logic           wake,
    output logic           rst_req
);

    localparam ctl_t CTL_RST = '{state: ST_AWAKE, mode: MD_IDLE, gate: '1,
                                 wake: 1'b0, rst_req: 1'b0, adc_start: 1'b0};

    ctl_t ctl_d, ctl_q;

    logic [2:0]     dec_mode_in;
    mode_e          dec_mode;
    gate_t          dec_gate;
    logic [NWK-1:0] dec_mask;
    logic           dec_deep;
    logic           dec_adc_trig;
    logic           lvl_ok;
    logic           dly_done;
    logic [NWK-1:0] wk_hit;

    // While awake the decoder looks at the requested code, while asleep at the latched one
    assign dec_mode_in = (ctl_q.state == ST_AWAKE) ? mode_sel : {1'b0, ctl_q.mode};

    slp_mode_decode u_dec (
        .mode_raw_i (dec_mode_in),
        .async_i    (async_sel),
        .tmr_ie_i   (tmr_ie),
        .gie_i      (gie),
        .mode_o     (dec_mode),
        .gate_o     (dec_gate),
        .mask_o     (dec_mask),
        .deep_o     (dec_deep),
        .adc_trig_o (dec_adc_trig)
    );

    slp_lvl_filter #(.LVL_HOLD(LVL_HOLD)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (!(ctl_q.state == ST_SLEEPING && dec_deep)),
        .lvl_i (wake_req[WK_EXTLVL]),
        .ok_o  (lvl_ok)
    );

    slp_dly_timer #(.DLY_BASE(DLY_BASE)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (ctl_q.state == ST_OSC_STARTUP),
        .sel_i  (startup_sel),
        .done_o (dly_done)
    );

    always_comb begin
        wk_hit = wake_req & dec_mask;
        if (dec_deep) wk_hit[WK_EXTLVL] = dec_mask[WK_EXTLVL] & lvl_ok;

        ctl_d           = ctl_q;
        ctl_d.wake      = 1'b0;
        ctl_d.rst_req   = 1'b0;
        ctl_d.adc_start = 1'b0;

        unique case (ctl_q.state)
            ST_AWAKE: begin
                if (sleep_cmd && sleep_en) begin
                    ctl_d.state     = ST_SLEEPING;
                    ctl_d.mode      = dec_mode;
                    ctl_d.gate      = dec_gate;
                    ctl_d.adc_start = adc_en && dec_adc_trig;
                end
            end
            ST_SLEEPING: begin
                if (|rst_src) begin
                    ctl_d.state   = ST_AWAKE;
                    ctl_d.gate    = '1;
                    ctl_d.rst_req = 1'b1;
                end else if (|wk_hit) begin
                    if (dec_deep) begin
                        ctl_d.state    = ST_OSC_STARTUP;
                        ctl_d.gate.osc = 1'b1;
                    end else begin
                        ctl_d.state = ST_RESUME;
                        ctl_d.gate  = '1;
                        ctl_d.wake  = 1'b1;
                    end
                end
            end
            ST_OSC_STARTUP: begin
                if (|rst_src) begin
                    ctl_d.state   = ST_AWAKE;
                    ctl_d.gate    = '1;
                    ctl_d.rst_req = 1'b1;
                end else if (dly_done) begin
                    ctl_d.state = ST_RESUME;
                    ctl_d.gate  = '1;
                    ctl_d.wake  = 1'b1;
                end
            end
            ST_RESUME: begin
                ctl_d.state = ST_AWAKE;
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign clk_en_cpu   = ctl_q.gate.cpu;
    assign clk_en_flash = ctl_q.gate.flash;
    assign clk_en_io    = ctl_q.gate.io;
    assign clk_en_adc   = ctl_q.gate.adc;
    assign clk_en_atmr  = ctl_q.gate.atmr;
    assign osc_en       = ctl_q.gate.osc;
    assign adc_start    = ctl_q.adc_start;
    assign wake         = ctl_q.wake;
    assign rst_req      = ctl_q.rst_req;

    // R12: wake is a single-cycle pulse
    assert_wake_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    // R11: a reset exit never coincides with a wake pulse
    assert_rst_no_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !wake);

    // R3: the core and program memory clocks stay off for the whole sleep
    assert_core_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_SLEEPING || ctl_q.state == ST_OSC_STARTUP)
        |-> (!clk_en_cpu && !clk_en_flash));

    // R10: during start-up the oscillator runs while the I/O clock is still gated
    assert_osc_startup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_OSC_STARTUP) |-> (osc_en && !clk_en_io));

    // R5: conversion start lasts one cycle
    assert_adc_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R3: the oscillator is off only in a deep mode
    assert_osc_deep_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_SLEEPING && !osc_en)
        |-> (ctl_q.mode == MD_STOP || ctl_q.mode == MD_SAVE));

endmodule

// File: tb/tb_slp_clkgate_ctrl.sv
module tb_slp_clkgate_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sleep_cmd, sleep_en, adc_en, async_sel, tmr_ie, gie;
    logic [2:0] mode_sel;
    logic [1:0] startup_sel;
    logic [7:0] wake_req;
    logic [2:0] rst_src;
    logic       clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_atmr, osc_en;
    logic       adc_start, wake, rst_req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    slp_clkgate_ctrl #(.DLY_BASE(4), .LVL_HOLD(4)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .sleep_en(sleep_en),
        .mode_sel(mode_sel), .adc_en(adc_en), .async_sel(async_sel), .tmr_ie(tmr_ie),
        .gie(gie), .startup_sel(startup_sel), .wake_req(wake_req), .rst_src(rst_src),
        .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash), .clk_en_io(clk_en_io),
        .clk_en_adc(clk_en_adc), .clk_en_atmr(clk_en_atmr), .osc_en(osc_en),
        .adc_start(adc_start), .wake(wake), .rst_req(rst_req)
    );

    // {mode[2:0], adc_en, async, gates{osc,atmr,adc,io,flash,cpu}, adc_exp, latency[7:0]}
    localparam logic [19:0] VEC [10] = '{
        {3'b000, 1'b1, 1'b0, 6'b111100, 1'b1, 8'd1},
        {3'b001, 1'b1, 1'b0, 6'b111000, 1'b1, 8'd1},
        {3'b010, 1'b1, 1'b0, 6'b000000, 1'b0, 8'd5},
        {3'b011, 1'b0, 1'b0, 6'b000000, 1'b0, 8'd5},
        {3'b011, 1'b0, 1'b1, 6'b010000, 1'b0, 8'd5},
        {3'b100, 1'b0, 1'b0, 6'b111100, 1'b0, 8'd1},
        {3'b101, 1'b1, 1'b0, 6'b111100, 1'b1, 8'd1},
        {3'b110, 1'b0, 1'b0, 6'b111100, 1'b0, 8'd1},
        {3'b111, 1'b0, 1'b0, 6'b111100, 1'b0, 8'd1},
        {3'b000, 1'b0, 1'b0, 6'b111100, 1'b0, 8'd1}
    };

    function automatic logic [5:0] gates();
        return {osc_en, clk_en_atmr, clk_en_adc, clk_en_io, clk_en_flash, clk_en_cpu};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sleep_cmd = 0; sleep_en = 0; adc_en = 0; async_sel = 0;
        tmr_ie = 0; gie = 0; mode_sel = 0; startup_sel = 0; wake_req = 0; rst_src = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic enter(input logic [2:0] m);
        mode_sel = m; sleep_en = 1'b1; sleep_cmd = 1'b1;
        tick();
        sleep_cmd = 1'b0;
    endtask

    // Applies a request and counts edges until wake; records osc/cpu after the second edge
    task automatic wake_lat(input logic [7:0] req, input bit hold, input int limit,
                            output int n, output logic osc2, output logic cpu2);
        wake_req = req; n = 0; osc2 = 0; cpu2 = 1;
        for (int i = 0; i < limit; i++) begin
            tick();
            n++;
            if (!hold) wake_req = '0;
            if (n == 2) begin osc2 = osc_en; cpu2 = clk_en_cpu; end
            if (wake) break;
        end
        wake_req = '0;
        if (!wake) n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int   n;
        logic o2, c2;

        do_reset();
        // R1: reset state
        check(gates() == 6'b111111, "R1 enables", gates(), 6'b111111);
        check({wake, rst_req, adc_start} == 3'b000, "R1 pulses",
              {wake, rst_req, adc_start}, 0);

        // Table walk: R3 R4 R5 R9 R10 R12
        for (int v = 0; v < 10; v++) begin
            logic [19:0] e;
            e = VEC[v];
            do_reset();
            adc_en = e[16]; async_sel = e[15];
            enter(e[19:17]);
            check(gates() == e[14:9], $sformatf("R3/R4 gates vec%0d", v), gates(), e[14:9]);
            check(adc_start == e[8], $sformatf("R5 adc_start vec%0d", v), adc_start, e[8]);
            tick();
            check(adc_start == 1'b0, $sformatf("R5 adc pulse width vec%0d", v), adc_start, 0);
            wake_lat(8'h02, 1'b0, 300, n, o2, c2);
            check(n == int'(e[7:0]), $sformatf("R9/R10 latency vec%0d", v), n, e[7:0]);
            check(gates() == 6'b111111, $sformatf("R9/R10 restore vec%0d", v), gates(), 6'h3f);
            if (e[7:0] > 1)
                check(o2 == 1'b1 && c2 == 1'b0, $sformatf("R10 osc startup vec%0d", v),
                      {o2, c2}, 2'b10);
            tick();
            check(wake == 1'b0, $sformatf("R12 wake width vec%0d", v), wake, 0);
        end

        // R2: strobe ignored when sleep disabled
        do_reset();
        mode_sel = 3'b010; sleep_en = 1'b0; sleep_cmd = 1'b1;
        tick(); sleep_cmd = 1'b0;
        check(gates() == 6'b111111, "R2 sleep_en low", gates(), 6'h3f);

        // R2: strobe ignored while asleep (idle stays idle after a deep-stop strobe)
        enter(3'b000);
        mode_sel = 3'b010; sleep_cmd = 1'b1; tick(); sleep_cmd = 1'b0;
        check(gates() == 6'b111100, "R2 strobe while asleep", gates(), 6'b111100);

        // R12: back awake, a new strobe is accepted
        wake_lat(8'h80, 1'b0, 20, n, o2, c2);
        check(n == 1, "R6 idle accepts other irq", n, 1);
        tick();
        enter(3'b001);
        check(gates() == 6'b111000, "R12 re-entry after wake", gates(), 6'b111000);

        // R6: converter quiet ignores bit 7, accepts bit 0
        wake_lat(8'h80, 1'b0, 20, n, o2, c2);
        check(n == 0 && gates() == 6'b111000, "R6 quiet ignores bit7", gates(), 6'b111000);
        wake_lat(8'h01, 1'b0, 20, n, o2, c2);
        check(n == 1, "R6 quiet accepts bit0", n, 1);

        // R6: deep stop ignores converter done
        do_reset();
        enter(3'b010);
        wake_lat(8'h01, 1'b0, 30, n, o2, c2);
        check(n == 0 && gates() == 6'b000000, "R6 stop ignores bit0", gates(), 0);
        wake_lat(8'h20, 1'b0, 30, n, o2, c2);
        check(n == 5, "R6 stop accepts bit5", n, 5);

        // R7: timer wake in deep save needs gie
        do_reset();
        async_sel = 1; tmr_ie = 1; gie = 0;
        enter(3'b011);
        wake_lat(8'h04, 1'b0, 30, n, o2, c2);
        check(n == 0, "R7 save timer ignored without gie", n, 0);
        gie = 1;
        wake_lat(8'h04, 1'b0, 30, n, o2, c2);
        check(n == 5, "R7 save timer with gie", n, 5);

        // R8: level request held too briefly in deep stop
        do_reset();
        enter(3'b010);
        wake_req = 8'h10;
        repeat (3) tick();
        wake_req = 8'h00;
        repeat (10) tick();
        check(gates() == 6'b000000 && wake == 0, "R8 short level ignored", gates(), 0);
        wake_lat(8'h10, 1'b1, 40, n, o2, c2);
        check(n == 8, "R8 held level accepted", n, 8);

        // R8: level request immediate in idle
        do_reset();
        enter(3'b000);
        wake_lat(8'h10, 1'b1, 40, n, o2, c2);
        check(n == 1, "R8 idle level immediate", n, 1);

        // R10: longer start-up selection
        do_reset();
        startup_sel = 2'd2;
        enter(3'b010);
        wake_lat(8'h02, 1'b0, 300, n, o2, c2);
        check(n == 65, "R10 startup_sel 2", n, 65);

        // R11: reset source while asleep
        do_reset();
        enter(3'b010);
        rst_src = 3'b010;
        tick();
        rst_src = 3'b000;
        check(rst_req == 1 && wake == 0, "R11 rst_req", {rst_req, wake}, 2'b10);
        check(gates() == 6'b111111, "R11 enables restored", gates(), 6'h3f);
        tick();
        check(rst_req == 0 && wake == 0, "R11 single pulse", {rst_req, wake}, 0);

        // R11: reset source during oscillator start-up
        enter(3'b010);
        wake_req = 8'h02; tick(); wake_req = 8'h00;
        tick();
        rst_src = 3'b001; tick(); rst_src = 3'b000;
        check(rst_req == 1 && wake == 0 && gates() == 6'h3f, "R11 during startup",
              {rst_req, wake, gates()}, {2'b10, 6'h3f});

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule